// File: doc/BRIEF.md
# Scratchpad Register File with Indirect Pointer

This block is a 64-word, 8-bit scratchpad register file. A 4-bit select field picks one word per access. Small select values name a word directly. The upper select values route the access through a 6-bit pointer register. These pointer modes either keep the pointer as it is or step its low 3-bit half up or down after the access. The step stays inside the low half, so a loop can walk eight consecutive words while the upper half holds the bank fixed.

The pointer can be written in three ways:
- all six bits at once from an accumulator value;
- the upper 3-bit half alone from a 3-bit immediate;
- the lower 3-bit half alone from the same immediate.

A flag reports whether the low half is anything other than 7. This lets a sequencer stop a stepping loop at the end of a bank.

Reads are combinational from the selected word. Writes, pointer steps and pointer loads all take effect on the rising clock edge. Instruction decoding is done outside this block.

Top module: `ptr_regfile`

## Requirements
- R1: With `acc_valid` high, select values 0x0 to 0xB address words 0 to 11 directly. A read returns that word combinationally. A write with `wr_en` high stores `wr_data` there at the clock edge.
- R2: Select value 0xC addresses the word numbered by `ptr_out`. The pointer is left unchanged.
- R3: Select value 0xD addresses the word at `ptr_out`. At the edge of a valid access it adds 1 to the low 3 bits, wrapping 7 to 0. The upper 3 bits are not affected.
- R4: Select value 0xE addresses the word at `ptr_out`. At the edge of a valid access it subtracts 1 from the low 3 bits, wrapping 0 to 7. The upper 3 bits are not affected.
- R5: Select value 0xF writes nothing, leaves the pointer unchanged and drives `rd_data` to zero.
- R6: `ptr_ld_full` loads all 6 pointer bits from `ptr_word` at the clock edge.
- R7: `ptr_ld_hi` loads bits 5:3 of the pointer from `ptr_imm`. `ptr_ld_lo` loads bits 2:0 from `ptr_imm`. Each half is loaded without touching the other, and both may be loaded in the same cycle.
- R8: `lo_not_max` is high exactly when bits 2:0 of `ptr_out` differ from 7.
- R9: Synchronous reset clears the pointer to 0.
- R10: Several pointer updates in one cycle resolve by priority:
  - a full load beats both half loads and any step;
  - a low-half load beats a step;
  - an upper-half load combines with a step of the low half.
- R11: With `acc_valid` low, no write happens and the pointer does not step. `rd_data` still shows the selected word.
- R12: The word read in a cycle is the one at the pointer value before that cycle's edge. A word written at an edge is visible on `rd_data` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is made this cycle |
| wr_en | input | 1 | The access writes `wr_data` |
| sel | input | SEL_W (4) | Access mode and direct register number |
| wr_data | input | DATA_W (8) | Write data |
| rd_data | output | DATA_W (8) | Combinational read data |
| ptr_ld_full | input | 1 | Load the whole pointer from `ptr_word` |
| ptr_ld_hi | input | 1 | Load the upper pointer half from `ptr_imm` |
| ptr_ld_lo | input | 1 | Load the lower pointer half from `ptr_imm` |
| ptr_word | input | 2*HALF_W (6) | Full pointer load value, taken from the accumulator |
| ptr_imm | input | HALF_W (3) | Half load immediate |
| ptr_out | output | 2*HALF_W (6) | Current pointer |
| lo_not_max | output | 1 | Low pointer half is not all ones |

## Verification
The bench builds the block with its default parameters: 8-bit words, 3-bit pointer halves and 12 direct registers. With these values both wrap points of the low half (7 to 0 upward, 0 to 7 downward) are reached within a few steps. The top word of the file and the boundary between direct and pointer-based select codes can also be hit with short sequences. The vector walk deliberately pairs steps with half and full loads in the same cycle, so every branch of the update priority is exercised. It also checks that the undefined code and idle cycles leave the words and the pointer untouched.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

  // Kind of access selected by the select field.
  typedef enum logic [2:0] {
    AK_DIRECT,
    AK_KEEP,
    AK_INC,
    AK_DEC,
    AK_NONE
  } acc_kind_t;

endpackage

// File: rtl/ptr_regfile_dec.sv
module ptr_regfile_dec
  import ptr_regfile_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int ADDR_W     = 6,
  parameter int DIRECT_CNT = 12
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] ptr,
  output acc_kind_t         kind,
  output logic [ADDR_W-1:0] addr
);

  // The three pointer modes sit directly after the direct range.
  localparam int KEEP_CODE = DIRECT_CNT;
  localparam int INC_CODE  = DIRECT_CNT + 1;
  localparam int DEC_CODE  = DIRECT_CNT + 2;

  always_comb begin
    kind = AK_NONE;
    addr = ptr;
    if (int'(sel) < DIRECT_CNT) begin
      kind = AK_DIRECT;
      addr = ADDR_W'(sel);
    end else if (int'(sel) == KEEP_CODE) begin
      kind = AK_KEEP;
    end else if (int'(sel) == INC_CODE) begin
      kind = AK_INC;
    end else if (int'(sel) == DEC_CODE) begin
      kind = AK_DEC;
    end
  end

endmodule

// File: rtl/ptr_regfile_ptr.sv
module ptr_regfile_ptr #(
  parameter int HALF_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_up,
  input  logic                step_dn,
  input  logic                ld_all,
  input  logic                ld_hi,
  input  logic                ld_lo,
  input  logic [2*HALF_W-1:0] ld_word,
  input  logic [HALF_W-1:0]   imm,
  output logic [2*HALF_W-1:0] ptr
);

  logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d;

  // Priority from low to high: step, half load, full load.
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (step_up) begin
      lo_d = lo_q + HALF_W'(1);
    end else if (step_dn) begin
      lo_d = lo_q - HALF_W'(1);
    end
    if (ld_hi) hi_d = imm;
    if (ld_lo) lo_d = imm;
    if (ld_all) {hi_d, lo_d} = ld_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign ptr = {hi_q, lo_q};

endmodule

// File: rtl/ptr_regfile_mem.sv
module ptr_regfile_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // No reset on the array, so it maps onto distributed RAM.
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_regfile_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_W     = 3,
  parameter int SEL_W      = 4,
  parameter int DIRECT_CNT = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ptr_ld_full,
  input  logic                ptr_ld_hi,
  input  logic                ptr_ld_lo,
  input  logic [2*HALF_W-1:0] ptr_word,
  input  logic [HALF_W-1:0]   ptr_imm,
  output logic [2*HALF_W-1:0] ptr_out,
  output logic                lo_not_max
);

  localparam int ADDR_W = 2 * HALF_W;
  localparam int DEPTH  = 2 ** ADDR_W;

  acc_kind_t         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] mem_rd;
  logic              mem_we;
  logic              step_up, step_dn;

  ptr_regfile_dec #(
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W),
    .DIRECT_CNT(DIRECT_CNT)
  ) u_dec (
    .sel (sel),
    .ptr (ptr_out),
    .kind(kind),
    .addr(addr)
  );

  assign mem_we  = acc_valid && wr_en && (kind != AK_NONE);
  assign step_up = acc_valid && (kind == AK_INC);
  assign step_dn = acc_valid && (kind == AK_DEC);

  ptr_regfile_ptr #(
    .HALF_W(HALF_W)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .step_up(step_up),
    .step_dn(step_dn),
    .ld_all (ptr_ld_full),
    .ld_hi  (ptr_ld_hi),
    .ld_lo  (ptr_ld_lo),
    .ld_word(ptr_word),
    .imm    (ptr_imm),
    .ptr    (ptr_out)
  );

  ptr_regfile_mem #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr),
    .wdata(wr_data),
    .rdata(mem_rd)
  );

  assign rd_data    = (kind == AK_NONE) ? '0 : mem_rd;
  assign lo_not_max = (ptr_out[HALF_W-1:0] != '1);

endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
  parameter int DATA_W     = 8,
  parameter int HALF_W     = 3,
  parameter int SEL_W      = 4,
  parameter int DIRECT_CNT = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic [SEL_W-1:0]    sel,
  input logic                ptr_ld_full,
  input logic                ptr_ld_hi,
  input logic                ptr_ld_lo,
  input logic [2*HALF_W-1:0] ptr_word,
  input logic [DATA_W-1:0]   rd_data,
  input logic [2*HALF_W-1:0] ptr_out
);

  localparam logic [SEL_W-1:0] KEEP_C = SEL_W'(DIRECT_CNT);
  localparam logic [SEL_W-1:0] INC_C  = SEL_W'(DIRECT_CNT + 1);
  localparam logic [SEL_W-1:0] DEC_C  = SEL_W'(DIRECT_CNT + 2);
  localparam logic [SEL_W-1:0] NONE_C = SEL_W'(DIRECT_CNT + 3);

  logic no_load;
  assign no_load = !ptr_ld_full && !ptr_ld_hi && !ptr_ld_lo;

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ptr_out == '0);

  a_r2_keep_stable: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel == KEEP_C && no_load) |=> $stable(ptr_out));

  a_r3_inc_low: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel == INC_C && !ptr_ld_full && !ptr_ld_lo)
    |=> ptr_out[HALF_W-1:0] == HALF_W'($past(ptr_out[HALF_W-1:0]) + HALF_W'(1)));

  a_r3_inc_no_carry: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel == INC_C && no_load)
    |=> $stable(ptr_out[2*HALF_W-1:HALF_W]));

  a_r4_dec_low: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel == DEC_C && !ptr_ld_full && !ptr_ld_lo)
    |=> ptr_out[HALF_W-1:0] == HALF_W'($past(ptr_out[HALF_W-1:0]) - HALF_W'(1)));

  a_r4_dec_no_borrow: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel == DEC_C && no_load)
    |=> $stable(ptr_out[2*HALF_W-1:HALF_W]));

  a_r5_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (sel == NONE_C) |-> rd_data == '0);

  a_r5_undef_ptr: assert property (@(posedge clk) disable iff (rst)
    (sel == NONE_C && no_load) |=> $stable(ptr_out));

  a_r6_full_load: assert property (@(posedge clk) disable iff (rst)
    ptr_ld_full |=> ptr_out == $past(ptr_word));

  a_r11_idle_ptr: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && no_load) |=> $stable(ptr_out));

endmodule

bind ptr_regfile ptr_regfile_chk #(
  .DATA_W    (DATA_W),
  .HALF_W    (HALF_W),
  .SEL_W     (SEL_W),
  .DIRECT_CNT(DIRECT_CNT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .sel        (sel),
  .ptr_ld_full(ptr_ld_full),
  .ptr_ld_hi  (ptr_ld_hi),
  .ptr_ld_lo  (ptr_ld_lo),
  .ptr_word   (ptr_word),
  .rd_data    (rd_data),
  .ptr_out    (ptr_out)
);

// File: tb/test_ptr_regfile.sv
module test_ptr_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, wr_en = 1'b0;
  logic [3:0] sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       ptr_ld_full = 1'b0, ptr_ld_hi = 1'b0, ptr_ld_lo = 1'b0;
  logic [5:0] ptr_word = '0, ptr_out;
  logic [2:0] ptr_imm = '0;
  logic       lo_not_max;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ptr_regfile i_ptr_regfile (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .rd_data(rd_data), .ptr_ld_full(ptr_ld_full),
    .ptr_ld_hi(ptr_ld_hi), .ptr_ld_lo(ptr_ld_lo), .ptr_word(ptr_word),
    .ptr_imm(ptr_imm), .ptr_out(ptr_out), .lo_not_max(lo_not_max)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       v, we;
    logic [3:0] sel;
    logic [7:0] wd;
    logic       la, lh, ll;
    logic [5:0] word;
    logic [2:0] imm;
    logic       chk;
    logic [7:0] erd;
    logic [5:0] eptr;
  } vec_t;

  // Fields: req, valid, wr_en, sel, wr_data, ld_full, ld_hi, ld_lo, word, imm,
  // check-read, expected rd_data, expected pointer after the edge.
  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1,1,4'h0,8'h11, 0,0,0,6'h00,3'd0, 0,8'h00,6'h00}, // R1 write word 0
    '{4'd1, 1,1,4'hB,8'hB5, 0,0,0,6'h00,3'd0, 0,8'h00,6'h00}, // R1 write word 11
    '{4'd1, 1,0,4'h0,8'h00, 0,0,0,6'h00,3'd0, 1,8'h11,6'h00}, // R1 read word 0
    '{4'd1, 1,0,4'hB,8'h00, 0,0,0,6'h00,3'd0, 1,8'hB5,6'h00}, // R1 read word 11
    '{4'd6, 0,0,4'h0,8'h00, 1,0,0,6'h05,3'd0, 0,8'h00,6'h05}, // R6 full load
    '{4'd2, 1,1,4'hC,8'h5A, 0,0,0,6'h00,3'd0, 0,8'h00,6'h05}, // R2 write via ptr
    '{4'd2, 1,0,4'h5,8'h00, 0,0,0,6'h00,3'd0, 1,8'h5A,6'h05}, // R2 seen directly
    '{4'd7, 0,0,4'h0,8'h00, 0,1,0,6'h00,3'd3, 0,8'h00,6'h1D}, // R7 upper load
    '{4'd3, 1,1,4'hD,8'h77, 0,0,0,6'h00,3'd0, 0,8'h00,6'h1E}, // R3 step up
    '{4'd3, 1,1,4'hD,8'h78, 0,0,0,6'h00,3'd0, 0,8'h00,6'h1F}, // R3 step up
    '{4'd3, 1,1,4'hD,8'h79, 0,0,0,6'h00,3'd0, 0,8'h00,6'h18}, // R3 wrap, no carry
    '{4'd4, 1,1,4'hE,8'h80, 0,0,0,6'h00,3'd0, 0,8'h00,6'h1F}, // R4 wrap, no borrow
    '{4'd2, 1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'h79,6'h1F}, // R2 read
    '{4'd4, 1,0,4'hE,8'h00, 0,0,0,6'h00,3'd0, 1,8'h79,6'h1E}, // R4 read+step
    '{4'd4, 1,0,4'hE,8'h00, 0,0,0,6'h00,3'd0, 1,8'h78,6'h1D}, // R4 read+step
    '{4'd12,1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'h77,6'h1D}, // R12
    '{4'd5, 1,1,4'hF,8'hEE, 0,0,0,6'h00,3'd0, 1,8'h00,6'h1D}, // R5 undefined
    '{4'd5, 1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'h77,6'h1D}, // R5 no write
    '{4'd12,1,0,4'hC,8'h00, 0,0,1,6'h00,3'd0, 1,8'h77,6'h18}, // R12 old ptr read
    '{4'd7, 1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'h80,6'h18}, // R7 low load
    '{4'd11,0,1,4'hD,8'h99, 0,0,0,6'h00,3'd0, 1,8'h80,6'h18}, // R11 idle
    '{4'd11,1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'h80,6'h18}, // R11 no write
    '{4'd10,1,0,4'hD,8'h00, 0,0,1,6'h00,3'd6, 1,8'h80,6'h1E}, // R10 low load wins
    '{4'd10,1,0,4'hE,8'h00, 0,1,0,6'h00,3'd1, 1,8'h78,6'h0D}, // R10 hi load + step
    '{4'd10,1,0,4'hD,8'h00, 1,1,0,6'h3F,3'd0, 0,8'h00,6'h3F}, // R10 full load wins
    '{4'd2, 1,1,4'hC,8'hC3, 0,0,0,6'h00,3'd0, 0,8'h00,6'h3F}, // R2 top word
    '{4'd1, 1,0,4'hB,8'h00, 0,0,0,6'h00,3'd0, 1,8'hB5,6'h3F}, // R1 intact
    '{4'd2, 1,0,4'hC,8'h00, 0,0,0,6'h00,3'd0, 1,8'hC3,6'h3F}, // R2 read top
    '{4'd7, 0,0,4'h0,8'h00, 0,1,1,6'h00,3'd2, 0,8'h00,6'h12}  // R7 both halves
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle_inputs();
    acc_valid = 0; wr_en = 0; sel = '0; wr_data = '0;
    ptr_ld_full = 0; ptr_ld_hi = 0; ptr_ld_lo = 0; ptr_word = '0; ptr_imm = '0;
  endtask

  // One cycle: drive, check read mid-cycle, check pointer after the edge.
  task automatic step_ptr(string tag, logic [5:0] exp_ptr);
    @(posedge clk); #1;
    check(tag, 8'(ptr_out), 8'(exp_ptr));
    check({tag, " R8"}, 8'(lo_not_max), 8'(exp_ptr[2:0] != 3'd7));
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R9 reset state
    check("R9", 8'(ptr_out), 8'h00);
    check("R9", 8'(lo_not_max), 8'h01);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      acc_valid = VECS[i].v; wr_en = VECS[i].we; sel = VECS[i].sel;
      wr_data = VECS[i].wd; ptr_ld_full = VECS[i].la; ptr_ld_hi = VECS[i].lh;
      ptr_ld_lo = VECS[i].ll; ptr_word = VECS[i].word; ptr_imm = VECS[i].imm;
      #2;
      if (VECS[i].chk) check(tag, rd_data, VECS[i].erd);
      step_ptr(tag, VECS[i].eptr);
    end
    idle_inputs();

    // R8 flag at the top of the low half and just below it
    ptr_ld_lo = 1; ptr_imm = 3'd7;
    step_ptr("R8 low=7", 6'h17);
    ptr_imm = 3'd6;
    step_ptr("R8 low=6", 6'h16);
    idle_inputs();

    // R5 undefined code reads zero for several pointer values
    for (int p = 0; p < 64; p += 21) begin
      ptr_ld_full = 1; ptr_word = 6'(p);
      step_ptr("R6", 6'(p));
      idle_inputs();
      acc_valid = 1; sel = 4'hF;
      #2;
      check("R5 read", rd_data, 8'h00);
      step_ptr("R5 ptr", 6'(p));
      idle_inputs();
    end

    // R9 reset during operation clears a loaded pointer
    ptr_ld_full = 1; ptr_word = 6'h2A;
    step_ptr("R6", 6'h2A);
    idle_inputs();
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    check("R9 mid-run", 8'(ptr_out), 8'h00);

    finish_run();
  end

endmodule